// File: doc/BRIEF.md
# Integer Execute Stage

This block is the decode-and-execute step of a small 32-bit load-store processor. It works on one instruction per evaluation and holds no state. It takes the fetched instruction word and the two source operands read from the register file. The first operand is the register named by the field at bits 25:21, and the second is the register named by bits 20:16. From these it produces the value to write back, the register index to write, a write strobe, an overflow trap and an illegal-instruction flag.

It executes register-register arithmetic and logic, immediate arithmetic and logic, load-upper-immediate and the three constant shifts. The immediate is either sign-extended or zero-extended, and the opcode decides which. Only the signed add and subtract forms can raise a trap. A trapped or illegal instruction never writes, and register 0 is never written.

Top module: `int_exec_unit`

## Requirements
- R1: With opcode 0, the function codes 32 (add), 33 (addu), 34 (sub) and 35 (subu) give the 32-bit sum or difference of the first operand and the second operand. The difference is taken as first minus second.
- R2: With opcode 0, the function codes 36, 37, 38 and 39 give the bitwise AND, OR, XOR and NOR of the two operands.
- R3: The opcode is bits 31:26. The register fields are bits 25:21 (first source), 20:16 (second source or I-type destination) and 15:11 (R-type destination), and the I-type immediate is bits 15:0. Opcode 0 writes to the bits 15:11 field and every other opcode writes to the bits 20:16 field. The word 0x21840021 adds 33 to the first operand and targets register 4.
- R4: Opcode 8 (addi) adds the immediate with bits 31:16 filled from immediate bit 15.
- R5: Opcodes 9 (addiu), 12 (andi), 13 (ori) and 14 (xori) use the immediate with bits 31:16 cleared.
- R6: The overflow trap rises on two's-complement overflow for function codes 32 and 34 and for opcode 8. It never rises for function codes 33 and 35 or for opcode 9.
- R7: While the overflow trap is high, the write strobe is low. The computed result still appears on the result port.
- R8: Opcode 15 (lui) returns the immediate in bits 31:16 with bits 15:0 zero. The first operand is ignored.
- R9: With opcode 0, function codes 0, 2 and 3 shift the second operand by the amount in bits 10:6. Code 0 shifts left and fills with zeros, code 2 shifts right and fills with zeros, and code 3 shifts right and fills with the sign bit. For example, 0xFF000000 shifted by 3 gives 0xF8000000, 0x1FE00000 and 0xFFE00000 for codes 0, 2 and 3.
- R10: An instruction whose destination index is 0 computes its result but keeps the write strobe low.
- R11: Any opcode not listed here, and any opcode-0 function code not listed here, raises the illegal flag. The write strobe and the overflow trap then stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word being executed |
| opnd_s | input | 32 | Value of the register in field 25:21 |
| opnd_t | input | 32 | Value of the register in field 20:16 |
| result | output | 32 | Computed write-back value |
| dest_idx | output | 5 | Register index to write |
| wr_en | output | 1 | Write strobe for the register file |
| ovf_trap | output | 1 | Signed overflow exception |
| illegal | output | 1 | Unrecognised instruction |

## Verification
The embedded checks assume that the instruction word and both operands are fully driven with known values whenever they are evaluated. The checks are skipped while any of these bits is X. The bench therefore sets all three inputs together and samples the outputs only after a quiet interval. The vectors place operands right at the signed overflow boundaries and test both immediate sign bits. They also cover destination index 0 and words outside the decoded set, so that each guarded implication is exercised.

// File: rtl/exu_pkg.sv
package exu_pkg;
    localparam int XLEN    = 32;
    localparam int REG_W   = 5;
    localparam int SHAMT_W = $clog2(XLEN);
    localparam int IMM_W   = 16;
    localparam int OPC_W   = 6;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR, ALU_SHF, ALU_LUI
    } alu_op_e;

    typedef enum logic [1:0] {
        SHF_LEFT, SHF_RLOG, SHF_RARI
    } shf_mode_e;

    typedef struct packed {
        alu_op_e   op;
        shf_mode_e shf;
        logic      use_imm;
        logic      imm_sext;
        logic      ovf_chk;
        logic      dst_rd;
        logic      legal;
    } ctrl_t;

    typedef struct packed {
        logic [OPC_W-1:0]   opc;
        logic [REG_W-1:0]   rs;
        logic [REG_W-1:0]   rt;
        logic [REG_W-1:0]   rd;
        logic [SHAMT_W-1:0] shamt;
        logic [5:0]         fn;
    } fields_t;

    function automatic logic [XLEN-1:0] widen_imm(input logic [IMM_W-1:0] imm,
                                                  input logic sext);
        return {{(XLEN-IMM_W){sext & imm[IMM_W-1]}}, imm};
    endfunction
endpackage

// File: rtl/exu_decode.sv
module exu_decode
    import exu_pkg::*;
(
    input  fields_t f,
    output ctrl_t   ctrl
);
    always_comb begin
        ctrl = '{op: ALU_ADD, shf: SHF_LEFT, use_imm: 1'b0, imm_sext: 1'b0,
                 ovf_chk: 1'b0, dst_rd: 1'b0, legal: 1'b1};
        unique case (f.opc)
            6'd0: begin
                ctrl.dst_rd = 1'b1;
                unique case (f.fn)
                    6'd32: ctrl.ovf_chk = 1'b1;
                    6'd33: ctrl.op = ALU_ADD;
                    6'd34: begin ctrl.op = ALU_SUB; ctrl.ovf_chk = 1'b1; end
                    6'd35: ctrl.op = ALU_SUB;
                    6'd36: ctrl.op = ALU_AND;
                    6'd37: ctrl.op = ALU_OR;
                    6'd38: ctrl.op = ALU_XOR;
                    6'd39: ctrl.op = ALU_NOR;
                    6'd0:  begin ctrl.op = ALU_SHF; ctrl.shf = SHF_LEFT; end
                    6'd2:  begin ctrl.op = ALU_SHF; ctrl.shf = SHF_RLOG; end
                    6'd3:  begin ctrl.op = ALU_SHF; ctrl.shf = SHF_RARI; end
                    default: ctrl.legal = 1'b0;
                endcase
            end
            6'd8:  begin ctrl.use_imm = 1'b1; ctrl.imm_sext = 1'b1; ctrl.ovf_chk = 1'b1; end
            6'd9:  ctrl.use_imm = 1'b1;
            6'd12: begin ctrl.use_imm = 1'b1; ctrl.op = ALU_AND; end
            6'd13: begin ctrl.use_imm = 1'b1; ctrl.op = ALU_OR;  end
            6'd14: begin ctrl.use_imm = 1'b1; ctrl.op = ALU_XOR; end
            6'd15: ctrl.op = ALU_LUI;
            default: ctrl.legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/exu_shift.sv
module exu_shift
    import exu_pkg::*;
#(
    parameter int W     = XLEN,
    parameter int AMT_W = $clog2(W)
) (
    input  logic [W-1:0]     din,
    input  logic [AMT_W-1:0] amt,
    input  shf_mode_e        mode,
    output logic [W-1:0]     dout
);
    logic [W-1:0] lvl [AMT_W+1];
    logic         fill;

    assign fill   = (mode == SHF_RARI) & din[W-1];
    assign lvl[0] = din;

    for (genvar s = 0; s < AMT_W; s++) begin : g_stage
        localparam int STEP = 1 << s;
        logic [W-1:0] moved;
        assign moved = (mode == SHF_LEFT)
                     ? {lvl[s][W-STEP-1:0], {STEP{1'b0}}}
                     : {{STEP{fill}}, lvl[s][W-1:STEP]};
        assign lvl[s+1] = amt[s] ? moved : lvl[s];
    end

    assign dout = lvl[AMT_W];
endmodule

// File: rtl/exu_alu.sv
module exu_alu
    import exu_pkg::*;
(
    input  ctrl_t            ctrl,
    input  logic [IMM_W-1:0] imm,
    input  logic [XLEN-1:0]  a,
    input  logic [XLEN-1:0]  b,
    input  logic [XLEN-1:0]  shf_res,
    output logic [XLEN-1:0]  res,
    output logic             ovf
);
    localparam int MSB = XLEN - 1;
    logic [XLEN-1:0] opb, sum, diff;

    always_comb begin
        opb  = ctrl.use_imm ? widen_imm(imm, ctrl.imm_sext) : b;
        sum  = a + opb;
        diff = a - opb;
        ovf  = 1'b0;
        unique case (ctrl.op)
            ALU_ADD: begin
                res = sum;
                ovf = (a[MSB] == opb[MSB]) && (sum[MSB] != a[MSB]);
            end
            ALU_SUB: begin
                res = diff;
                ovf = (a[MSB] != opb[MSB]) && (diff[MSB] != a[MSB]);
            end
            ALU_AND: res = a & opb;
            ALU_OR:  res = a | opb;
            ALU_XOR: res = a ^ opb;
            ALU_NOR: res = ~(a | opb);
            ALU_SHF: res = shf_res;
            ALU_LUI: res = {imm, {(XLEN-IMM_W){1'b0}}};
            default: res = '0;
        endcase
    end

    always_comb begin
        if (!$isunknown({ctrl, imm, a, b})) begin
            // R8: lower half of a lui result is clear
            p_lui_low_r8: assert (ctrl.op != ALU_LUI || res[IMM_W-1:0] == '0)
                else $error("lui low half not zero");
            // R5: zero-extended OR with a zero operand leaves upper half clear
            p_zext_upper_r5: assert (!(ctrl.use_imm && !ctrl.imm_sext && ctrl.op == ALU_OR
                                       && a == '0) || res[MSB:IMM_W] == '0)
                else $error("zero extension leaked into upper half");
        end
    end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
    import exu_pkg::*;
(
    input  logic [XLEN-1:0]  instr,
    input  logic [XLEN-1:0]  opnd_s,
    input  logic [XLEN-1:0]  opnd_t,
    output logic [XLEN-1:0]  result,
    output logic [REG_W-1:0] dest_idx,
    output logic             wr_en,
    output logic             ovf_trap,
    output logic             illegal
);
    fields_t         f;
    ctrl_t           ctrl;
    logic [XLEN-1:0] shf_res;
    logic            ovf_raw;

    assign f = fields_t'(instr);

    exu_decode u_dec (.f(f), .ctrl(ctrl));

    exu_shift #(.W(XLEN), .AMT_W(SHAMT_W)) u_shf (
        .din(opnd_t), .amt(f.shamt), .mode(ctrl.shf), .dout(shf_res)
    );

    exu_alu u_alu (
        .ctrl(ctrl), .imm(instr[IMM_W-1:0]), .a(opnd_s), .b(opnd_t),
        .shf_res(shf_res), .res(result), .ovf(ovf_raw)
    );

    always_comb begin
        dest_idx = ctrl.dst_rd ? f.rd : f.rt;
        illegal  = !ctrl.legal;
        ovf_trap = ctrl.legal && ctrl.ovf_chk && ovf_raw;
        wr_en    = ctrl.legal && !ovf_trap && (dest_idx != '0);
    end

    always_comb begin
        if (!$isunknown({instr, opnd_s, opnd_t})) begin
            p_ill_nowrite_r11: assert (!illegal || (!wr_en && !ovf_trap))
                else $error("illegal instruction wrote or trapped");
            p_ovf_nowrite_r7: assert (!ovf_trap || !wr_en)
                else $error("write during overflow trap");
            p_zero_dest_r10: assert (dest_idx != '0 || !wr_en)
                else $error("write to register 0");
            p_no_overflow_r6: assert (!(f.opc == 6'd9 || (f.opc == 6'd0 &&
                                      (f.fn == 6'd33 || f.fn == 6'd35))) || !ovf_trap)
                else $error("unsigned form raised overflow");
        end
    end
endmodule

// File: tb/sim_int_exec_unit.sv
module sim_int_exec_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr, opnd_s, opnd_t, result;
    logic [4:0]  dest_idx;
    logic        wr_en, ovf_trap, illegal;
    int          total = 0, bad = 0, cycles = 0;
    bit          done  = 1'b0;

    always #10 clk = ~clk;

    int_exec_unit u0 (.instr(instr), .opnd_s(opnd_s), .opnd_t(opnd_t), .result(result),
                      .dest_idx(dest_idx), .wr_en(wr_en), .ovf_trap(ovf_trap),
                      .illegal(illegal));

    function automatic logic [31:0] rw(int fn, int rs, int rt, int rd, int sh);
        return {6'd0, rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn[5:0]};
    endfunction
    function automatic logic [31:0] iw(int op, int rs, int rt, logic [15:0] imm);
        return {op[5:0], rs[4:0], rt[4:0], imm};
    endfunction

    localparam int N = 28;
    localparam logic [31:0] V_INS [N] = '{
        rw(32,1,2,3,0), rw(32,1,2,3,0), rw(33,1,2,3,0), rw(34,1,2,5,0),       // R1 R6 R6 R1
        rw(34,1,2,5,0), rw(35,1,2,5,0), rw(36,1,2,6,0), rw(37,1,2,6,0),       // R7 R1 R2 R2
        rw(38,1,2,6,0), rw(39,1,2,6,0), 32'h21840021, iw(8,1,9,16'hFFEC),     // R2 R2 R3 R4
        iw(9,1,9,16'h8000), iw(8,1,9,16'h0010), iw(9,1,9,16'hFFFF),           // R5 R6 R6
        iw(12,1,10,16'h8F0F), iw(13,1,10,16'h8001), iw(14,1,10,16'hFFFF),     // R5 R5 R5
        iw(15,7,11,16'h1B23), rw(0,0,2,12,3), rw(2,0,2,12,3), rw(3,0,2,12,3), // R8 R9 R9 R9
        rw(3,0,2,12,4), rw(32,1,2,0,0), iw(8,1,0,16'h0001),                   // R9 R10 R10
        iw(2,1,2,16'h0000), rw(1,1,2,3,0), rw(40,1,2,3,0)                     // R11 R11 R11
    };
    localparam logic [31:0] V_A [N] = '{
        32'd5, 32'h7FFFFFFF, 32'h7FFFFFFF, 32'd10, 32'h80000000, 32'd3,
        32'hF0F01234, 32'hF0F01234, 32'hF0F01234, 32'hF0F01234, 32'd100, 32'd5,
        32'd1, 32'h7FFFFFF0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h12340000, 32'hFFFF0000,
        32'hDEADBEEF, 32'd0, 32'd0, 32'd0, 32'd0, 32'd5, 32'd1, 32'd0,
        32'd0, 32'h7FFFFFFF
    };
    localparam logic [31:0] V_B [N] = '{
        32'd7, 32'd1, 32'd1, 32'd3, 32'd1, 32'd10,
        32'h0FF0FF00, 32'h0FF0FF00, 32'h0FF0FF00, 32'h0FF0FF00, 32'd0, 32'd0,
        32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0,
        32'h12345678, 32'hFF000000, 32'hFF000000, 32'hFF000000, 32'h40000000, 32'd7,
        32'd0, 32'd0, 32'd0, 32'd1
    };
    localparam logic [31:0] V_RES [N] = '{
        32'h0000000C, 32'h80000000, 32'h80000000, 32'd7, 32'h7FFFFFFF, 32'hFFFFFFF9,
        32'h00F01200, 32'hFFF0FF34, 32'hFF00ED34, 32'h000F00CB, 32'd133, 32'hFFFFFFF1,
        32'h00008001, 32'h80000000, 32'h0000FFFE, 32'h00008F0F, 32'h12348001, 32'hFFFFFFFF,
        32'h1B230000, 32'hF8000000, 32'h1FE00000, 32'hFFE00000, 32'h04000000, 32'h0000000C,
        32'd2, 32'd0, 32'd0, 32'd0
    };
    localparam logic [4:0] V_DST [N] = '{
        3, 3, 3, 5, 5, 5, 6, 6, 6, 6, 4, 9, 9, 9, 9, 10, 10, 10, 11, 12, 12, 12, 12, 0, 0, 0, 0, 0
    };
    // flags per vector: {wr_en, ovf_trap, illegal}
    localparam logic [2:0] V_FLG [N] = '{
        3'b100, 3'b010, 3'b100, 3'b100, 3'b010, 3'b100, 3'b100, 3'b100, 3'b100, 3'b100,
        3'b100, 3'b100, 3'b100, 3'b010, 3'b100, 3'b100, 3'b100, 3'b100, 3'b100, 3'b100,
        3'b100, 3'b100, 3'b100, 3'b000, 3'b000, 3'b001, 3'b001, 3'b001
    };
    localparam int V_REQ [N] = '{
        1, 6, 6, 1, 7, 1, 2, 2, 2, 2, 3, 4, 5, 6, 6, 5, 5, 5, 8, 9, 9, 9, 9, 10, 10, 11, 11, 11
    };

    task automatic check(string what, int req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic apply(logic [31:0] i, logic [31:0] a, logic [31:0] b);
        @(negedge clk);
        instr = i; opnd_s = a; opnd_t = b;
        #5;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        instr = '0; opnd_s = 32'h13579BDF; opnd_t = 32'h2468ACE0;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        // idle state: all-zero word is a legal shift into register 0, no write (R10)
        apply(32'h0, 32'h13579BDF, 32'h2468ACE0);
        check("idle wr_en", 10, {31'd0, wr_en}, 32'd0);
        check("idle illegal", 11, {31'd0, illegal}, 32'd0);
        check("idle ovf", 6, {31'd0, ovf_trap}, 32'd0);

        for (int k = 0; k < N; k++) begin
            apply(V_INS[k], V_A[k], V_B[k]);
            if (!V_FLG[k][0]) begin
                check($sformatf("vec%0d result", k), V_REQ[k], result, V_RES[k]);
                check($sformatf("vec%0d dest", k), V_REQ[k], {27'd0, dest_idx}, {27'd0, V_DST[k]});
            end
            check($sformatf("vec%0d flags", k), V_REQ[k],
                  {29'd0, wr_en, ovf_trap, illegal}, {29'd0, V_FLG[k]});
        end

        // R3: rd field at its top value, rt field ignored for R-type destination
        apply(rw(33, 4, 17, 31, 0), 32'd1, 32'd2);
        check("rd=31 dest", 3, {27'd0, dest_idx}, 32'd31);
        check("rd=31 write", 3, {31'd0, wr_en}, 32'd1);
        // R9: maximum shift amounts
        apply(rw(3, 0, 2, 8, 31), 32'd0, 32'h80000000);
        check("sra by 31", 9, result, 32'hFFFFFFFF);
        apply(rw(0, 0, 2, 8, 31), 32'd0, 32'h00000001);
        check("sll by 31", 9, result, 32'h80000000);
        apply(rw(2, 0, 2, 8, 31), 32'd0, 32'h80000000);
        check("srl by 31", 9, result, 32'h00000001);
        // R4: largest positive immediate with no overflow, then negative across zero
        apply(iw(8, 1, 3, 16'h7FFF), 32'h7FFF8000, 32'd0);
        check("addi edge result", 4, result, 32'h7FFFFFFF);
        check("addi edge ovf", 6, {31'd0, ovf_trap}, 32'd0);
        apply(iw(8, 1, 3, 16'h8000), 32'h80000000, 32'd0);
        check("addi neg ovf", 6, {31'd0, ovf_trap}, 32'd1);
        check("addi neg nowrite", 7, {31'd0, wr_en}, 32'd0);
        // R8: lui ignores first operand entirely
        apply(iw(15, 3, 4, 16'hFFFF), 32'hFFFFFFFF, 32'hFFFFFFFF);
        check("lui all ones", 8, result, 32'hFFFF0000);
        finish_run();
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 10000 && !done) begin
            total++; bad++;
            $display("FAIL R0 watchdog: actual=%0d expected<=10000", cycles);
            finish_run();
        end
    end
endmodule